// File: doc/BRIEF.md
# Geometry Input Packer

This block sits between a per-vertex processing stage and a geometry processing stage. A vertex processing stage emits a fixed number of 128-bit attribute words for each vertex. The geometry stage needs one wide input record made of a configured number of such words, which may span several vertices. The packer appends every incoming word to the next free slot of the record. When a vertex completes and the record holds all the inputs the geometry stage expects, the packer presents the whole record on a valid/ready launch port and starts the next record from slot zero.

Alongside each record the packer supplies a continuation bit. This bit is clear for the first primitive of a batch and becomes set, and stays set, once a record completes on a vertex whose index is not zero. A batch-start pulse clears the fill position, the per-vertex word count, the continuation bit and the drop flag. Two error indications are provided. The first marks words that were thrown away because the geometry input count is not a whole multiple of the per-vertex word count. The second marks a disagreement between the two configured copies of the per-vertex word total.

When the geometry path is not enabled, the attribute stream passes straight through to a direct vertex output port, and the record is left untouched.

Top module: `geo_input_packer`

## Requirements
- R1: The packer accumulates only while `geo_mode` equals 2. For any other value (0, 1 or 3), words are routed to the bypass port and never enter the record, and `rec_valid` never rises because of them.
- R2: The record size is G = `gs_in_m1` + 1 slots and the vertex size is V = `vs_out_b_m1` + 1 words. Copy B alone sets V. Word b of the k-th vertex since the record began lands in slot k*V + b. Slot s sits in bits [s*128 +: 128] of `rec_attrs`.
- R3: When a vertex's last word is accepted and the fill position has reached G, `rec_valid` is high from the following cycle. The next record then fills from slot 0. `rec_valid` never rises before the last word of a vertex.
- R4: A word that arrives while all G slots are already filled is accepted but discarded. It sets `err_drop`, which stays set until the next batch start.
- R5: While `rec_valid` is high and `rec_ready` is low, `rec_valid` and `rec_attrs` hold steady. In accumulate mode `in_ready` is low whenever `rec_valid` is high. A cycle with `rec_ready` high consumes the record.
- R6: `rec_cont` is the OR, over all records launched since the last batch start (including the current one), of "index of the vertex that completed the record is non-zero".
- R7: `batch_start` clears the fill position, the per-vertex word count, `rec_cont` and `err_drop`. In accumulate mode `in_ready` is low during the `batch_start` cycle.
- R8: `err_cfg` is high exactly when `vs_out_a_m1` differs from `vs_out_b_m1`.
- R9: In bypass, `byp_valid` follows `in_valid`, `byp_attr` follows `in_attr`, and `in_ready` follows `byp_ready`, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| batch_start | input | 1 | Pulse that opens a new batch |
| geo_mode | input | 2 | 2 = accumulate, other values = bypass |
| gs_in_m1 | input | CNT_W | Geometry input count minus one |
| vs_out_a_m1 | input | CNT_W | Per-vertex word total minus one, copy A |
| vs_out_b_m1 | input | CNT_W | Per-vertex word total minus one, copy B (used for counting) |
| in_valid | input | 1 | Attribute word valid |
| in_ready | output | 1 | Attribute word accepted |
| in_attr | input | ATTR_W | Attribute word |
| in_vtx_idx | input | IDX_W | Index of the vertex the word belongs to |
| byp_valid | output | 1 | Bypass word valid |
| byp_ready | input | 1 | Bypass sink ready |
| byp_attr | output | ATTR_W | Bypass word |
| rec_valid | output | 1 | Complete record waiting |
| rec_ready | input | 1 | Geometry stage takes the record |
| rec_attrs | output | SLOTS*ATTR_W | Record slots, slot 0 in the low bits |
| rec_cont | output | 1 | Primitive continuation bit for the record |
| err_drop | output | 1 | Sticky: a word was discarded |
| err_cfg | output | 1 | The two word-total copies disagree |

## Verification
The bench sweeps every pairing of record size and vertex size in the default configuration. It runs two records per pairing and computes each slot's expected word from the vertex and word numbers. This sweep exposes a packer that launches on a word count instead of on a vertex boundary, since such a design fires early when G is not a multiple of V. It also exposes a packer that writes dropped words over slot 0, or that forgets to flag them. The continuation bit is checked on the single-vertex records where the first launch index is zero, which catches a bit that is not sticky or that never starts clear.

Directed cases target the remaining corner cases:
- a word-total mismatch in which only counting by copy B gives the late launch;
- bypass words injected between two halves of a record, which would show up as corrupted slots;
- a mid-record batch start, where a missed clear would shift the next record;
- a long downstream stall, during which a leaky handshake would overwrite the held record.

// File: rtl/gsa_pkg.sv
package gsa_pkg;
   typedef enum logic [1:0] {
      GMODE_OFF  = 2'd0,
      GMODE_RSV1 = 2'd1,
      GMODE_ACC  = 2'd2,
      GMODE_RSV3 = 2'd3
   } gmode_e;
endpackage

// File: rtl/gsa_fill_ctrl.sv
module gsa_fill_ctrl #(
   parameter int SLOTS = 16,
   parameter int CNT_W = 4,
   localparam int SLOT_AW = $clog2(SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               beat,
   input  logic               rec_ready,
   input  logic [CNT_W-1:0]   gs_m1,
   input  logic [CNT_W-1:0]   vs_m1,
   output logic               wr_en,
   output logic [SLOT_AW-1:0] wr_slot,
   output logic               drop,
   output logic               launch,
   output logic               rec_valid
);
   localparam int FILL_W = $clog2(SLOTS + 1);

   if ((2 ** CNT_W) > SLOTS) begin : g_bad_cnt
      $error("gsa_fill_ctrl: CNT_W allows more inputs than SLOTS");
   end

   logic [FILL_W-1:0] fill_q, fill_inc, gs_cnt;
   logic [CNT_W-1:0]  vbeat_q;
   logic              room, vtx_end;

   assign gs_cnt   = FILL_W'(gs_m1) + FILL_W'(1);
   assign room     = fill_q < gs_cnt;
   assign wr_en    = beat & room;
   assign drop     = beat & ~room;
   assign wr_slot  = fill_q[SLOT_AW-1:0];
   assign fill_inc = room ? fill_q + FILL_W'(1) : fill_q;
   assign vtx_end  = beat && (vbeat_q == vs_m1);
   assign launch   = vtx_end && (fill_inc >= gs_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fill_q  <= '0;
         vbeat_q <= '0;
      end else if (beat) begin
         vbeat_q <= vtx_end ? '0 : vbeat_q + CNT_W'(1);
         fill_q  <= launch ? '0 : fill_inc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         rec_valid <= 1'b0;
      else if (launch)    rec_valid <= 1'b1;
      else if (rec_ready) rec_valid <= 1'b0;
   end

   assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FILL_W'(SLOTS));
   assert_launch_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (fill_q == '0));
   assert_launch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready && !launch) |=> rec_valid);
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fill_q == '0 && vbeat_q == '0));
endmodule

// File: rtl/gsa_slot_store.sv
module gsa_slot_store #(
   parameter int SLOTS  = 16,
   parameter int ATTR_W = 128,
   localparam int SLOT_AW = $clog2(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [SLOT_AW-1:0]      wr_slot,
   input  logic [ATTR_W-1:0]       wr_data,
   output logic [SLOTS*ATTR_W-1:0] rec_flat
);
   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [ATTR_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                   slot_q <= '0;
         else if (wr_en && (wr_slot == SLOT_AW'(i)))   slot_q <= wr_data;
      end
      assign rec_flat[i*ATTR_W +: ATTR_W] = slot_q;
   end
endmodule

// File: rtl/gsa_batch_flags.sv
module gsa_batch_flags #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             launch,
   input  logic             drop,
   input  logic [IDX_W-1:0] vtx_idx,
   output logic             cont,
   output logic             err_drop
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cont     <= 1'b0;
         err_drop <= 1'b0;
      end else begin
         if (launch) cont     <= cont | (vtx_idx != '0);
         if (drop)   err_drop <= 1'b1;
      end
   end

   assert_cont_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && !clr) |=> cont);
   assert_drop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && !clr) |=> err_drop);
   assert_batch_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!cont && !err_drop));
endmodule

// File: rtl/geo_input_packer.sv
module geo_input_packer #(
   parameter int ATTR_W = 128,
   parameter int SLOTS  = 16,
   parameter int CNT_W  = 4,
   parameter int IDX_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    batch_start,
   input  logic [1:0]              geo_mode,
   input  logic [CNT_W-1:0]        gs_in_m1,
   input  logic [CNT_W-1:0]        vs_out_a_m1,
   input  logic [CNT_W-1:0]        vs_out_b_m1,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [ATTR_W-1:0]       in_attr,
   input  logic [IDX_W-1:0]        in_vtx_idx,
   output logic                    byp_valid,
   input  logic                    byp_ready,
   output logic [ATTR_W-1:0]       byp_attr,
   output logic                    rec_valid,
   input  logic                    rec_ready,
   output logic [SLOTS*ATTR_W-1:0] rec_attrs,
   output logic                    rec_cont,
   output logic                    err_drop,
   output logic                    err_cfg
);
   import gsa_pkg::*;
   localparam int SLOT_AW = $clog2(SLOTS);

   if (ATTR_W < 1 || SLOTS < 2 || IDX_W < 1) begin : g_bad_param
      $error("geo_input_packer: illegal parameter set");
   end

   logic               acc, beat, wr_en, drop, launch;
   logic [SLOT_AW-1:0] wr_slot;

   assign acc       = (geo_mode == GMODE_ACC);
   assign in_ready  = acc ? (!rec_valid && !batch_start) : byp_ready;
   assign beat      = acc && in_valid && in_ready;
   assign byp_valid = !acc && in_valid;
   assign byp_attr  = in_attr;
   assign err_cfg   = (vs_out_a_m1 != vs_out_b_m1);

   gsa_fill_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .clr(batch_start), .beat(beat),
      .rec_ready(rec_ready), .gs_m1(gs_in_m1), .vs_m1(vs_out_b_m1),
      .wr_en(wr_en), .wr_slot(wr_slot), .drop(drop), .launch(launch),
      .rec_valid(rec_valid));

   gsa_slot_store #(.SLOTS(SLOTS), .ATTR_W(ATTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_data(in_attr), .rec_flat(rec_attrs));

   gsa_batch_flags #(.IDX_W(IDX_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(batch_start), .launch(launch),
      .drop(drop), .vtx_idx(in_vtx_idx), .cont(rec_cont), .err_drop(err_drop));

   assert_bypass_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !rec_valid) |=> !rec_valid);
   assert_backpressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && rec_valid) |-> !in_ready);
   assert_record_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> $stable(rec_attrs));
   assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |-> (in_ready == byp_ready && byp_valid == in_valid));
endmodule

// File: tb/geo_input_packer_bench.sv
`timescale 1ns/1ps
module geo_input_packer_bench;
   localparam int AW = 128;
   localparam int NS = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          batch_start = 1'b0;
   logic [1:0]    geo_mode = 2'd2;
   logic [3:0]    gs_in_m1 = '0, vs_out_a_m1 = '0, vs_out_b_m1 = '0;
   logic          in_valid = 1'b0, byp_ready = 1'b0, rec_ready = 1'b0;
   logic [AW-1:0] in_attr = '0;
   logic [15:0]   in_vtx_idx = '0;
   logic          in_ready, byp_valid, rec_valid, rec_cont, err_drop, err_cfg;
   logic [AW-1:0] byp_attr;
   logic [NS*AW-1:0] rec_attrs;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   geo_input_packer u_geo_input_packer (
      .clk(clk), .rst_n(rst_n), .batch_start(batch_start), .geo_mode(geo_mode),
      .gs_in_m1(gs_in_m1), .vs_out_a_m1(vs_out_a_m1), .vs_out_b_m1(vs_out_b_m1),
      .in_valid(in_valid), .in_ready(in_ready), .in_attr(in_attr),
      .in_vtx_idx(in_vtx_idx), .byp_valid(byp_valid), .byp_ready(byp_ready),
      .byp_attr(byp_attr), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_attrs(rec_attrs), .rec_cont(rec_cont), .err_drop(err_drop),
      .err_cfg(err_cfg));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mkw(int g, int v, int l, int vx, int b);
      return {16'hC0DE, 16'(g), 16'(v), 16'(l), 32'(vx), 32'(b)};
   endfunction

   // called at a negedge; returns at the negedge after the word is taken
   task automatic send(input logic [AW-1:0] d, input int idx);
      in_valid = 1'b1; in_attr = d; in_vtx_idx = 16'(idx);
      #1;
      while (!in_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_batch();
      batch_start = 1'b1;
      @(negedge clk);
      batch_start = 1'b0;
   endtask

   task automatic consume(input string req);
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
      chk(rec_valid == 1'b0, req, "record consumed", AW'(rec_valid), '0);
   endtask

   task automatic set_cfg(input int g, input int v);
      gs_in_m1 = 4'(g - 1); vs_out_a_m1 = 4'(v - 1); vs_out_b_m1 = 4'(v - 1);
   endtask

   // R2 R3 R4 R6: one pairing, two records
   task automatic run_combo(input int g, input int v);
      int nv, vidx, bad, bad_s;
      bit cont_exp;
      set_cfg(g, v);
      pulse_batch();
      nv = (g + v - 1) / v;
      vidx = 0;
      cont_exp = 0;
      for (int l = 0; l < 2; l++) begin
         for (int vx = 0; vx < nv; vx++) begin
            if (vx == nv - 1)
               chk(rec_valid == 1'b0, "R3", "no early launch", AW'(rec_valid), '0);
            for (int b = 0; b < v; b++) send(mkw(g, v, l, vx, b), vidx);
            vidx++;
         end
         chk(rec_valid == 1'b1, "R3", "launch after vertex", AW'(rec_valid), 1);
         bad = 0; bad_s = 0;
         for (int s = 0; s < g; s++)
            if (rec_attrs[s*AW +: AW] != mkw(g, v, l, s / v, s % v) && bad == 0) begin
               bad = 1; bad_s = s;
            end
         chk(bad == 0, "R2", $sformatf("slot %0d g=%0d v=%0d", bad_s, g, v),
             rec_attrs[bad_s*AW +: AW], mkw(g, v, l, bad_s / v, bad_s % v));
         cont_exp = cont_exp | ((vidx - 1) != 0);
         chk(rec_cont == cont_exp, "R6", $sformatf("cont g=%0d v=%0d l=%0d", g, v, l),
             AW'(rec_cont), AW'(cont_exp));
         if (l == 0)
            chk(err_drop == ((g % v) != 0), "R4", $sformatf("drop flag g=%0d v=%0d", g, v),
                AW'(err_drop), AW'((g % v) != 0));
         #1;
         chk(in_ready == 1'b0, "R5", "stall while pending", AW'(in_ready), '0);
         consume("R5");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // reset state
      chk(rec_valid == 1'b0, "R3", "reset rec_valid", AW'(rec_valid), '0);
      chk(err_drop == 1'b0, "R4", "reset err_drop", AW'(err_drop), '0);
      chk(rec_cont == 1'b0, "R6", "reset cont", AW'(rec_cont), '0);
      chk(in_ready == 1'b1, "R5", "reset in_ready", AW'(in_ready), 1);
      @(negedge clk);

      // R8 configuration mismatch
      vs_out_a_m1 = 4'd3; vs_out_b_m1 = 4'd5; #1;
      chk(err_cfg == 1'b1, "R8", "mismatch", AW'(err_cfg), 1);
      vs_out_a_m1 = 4'd5; #1;
      chk(err_cfg == 1'b0, "R8", "match", AW'(err_cfg), '0);
      @(negedge clk);

      // R2 copy B sets vertex size: G=3, A says 1, B says 2
      gs_in_m1 = 4'd2; vs_out_a_m1 = 4'd0; vs_out_b_m1 = 4'd1;
      pulse_batch();
      send(mkw(3, 2, 9, 0, 0), 0);
      send(mkw(3, 2, 9, 0, 1), 0);
      send(mkw(3, 2, 9, 1, 0), 1);
      chk(rec_valid == 1'b0, "R2", "copy B counts vertex", AW'(rec_valid), '0);
      chk(err_cfg == 1'b1, "R8", "mismatch during run", AW'(err_cfg), 1);
      send(mkw(3, 2, 9, 1, 1), 1);
      chk(rec_valid == 1'b1, "R2", "copy B launch", AW'(rec_valid), 1);
      chk(err_drop == 1'b1, "R4", "dropped fourth word", AW'(err_drop), 1);
      chk(rec_attrs[2*AW +: AW] == mkw(3, 2, 9, 1, 0), "R4", "slot 2 kept",
          rec_attrs[2*AW +: AW], mkw(3, 2, 9, 1, 0));
      consume("R5");

      // R5 long hold
      set_cfg(2, 1);
      pulse_batch();
      send(mkw(2, 1, 7, 0, 0), 0);
      send(mkw(2, 1, 7, 1, 0), 1);
      in_valid = 1'b1; in_attr = '1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); #1;
         chk(rec_valid == 1'b1 && rec_attrs[AW-1:0] == mkw(2, 1, 7, 0, 0), "R5",
             "held record", rec_attrs[AW-1:0], mkw(2, 1, 7, 0, 0));
         chk(in_ready == 1'b0, "R5", "held stall", AW'(in_ready), '0);
      end
      in_valid = 1'b0;
      consume("R5");

      // R1 R9 bypass between two halves of a record
      set_cfg(4, 2);
      pulse_batch();
      send(mkw(4, 2, 5, 0, 0), 0);
      send(mkw(4, 2, 5, 0, 1), 0);
      geo_mode = 2'd0; byp_ready = 1'b1;
      in_valid = 1'b1; in_attr = '1; #1;
      chk(byp_valid == 1'b1 && byp_attr == '1, "R9", "bypass word", byp_attr, '1);
      chk(in_ready == 1'b1, "R9", "bypass ready", AW'(in_ready), 1);
      @(negedge clk);
      byp_ready = 1'b0; #1;
      chk(in_ready == 1'b0, "R9", "bypass stall", AW'(in_ready), '0);
      geo_mode = 2'd3; byp_ready = 1'b1; #1;
      chk(byp_valid == 1'b1, "R1", "mode 3 bypasses", AW'(byp_valid), 1);
      @(negedge clk);
      geo_mode = 2'd1; #1;
      chk(byp_valid == 1'b1, "R1", "mode 1 bypasses", AW'(byp_valid), 1);
      @(negedge clk);
      in_valid = 1'b0; byp_ready = 1'b0; geo_mode = 2'd2; #1;
      chk(rec_valid == 1'b0, "R1", "no launch from bypass", AW'(rec_valid), '0);
      chk(byp_valid == 1'b0, "R1", "accumulate silences bypass", AW'(byp_valid), '0);
      @(negedge clk);
      send(mkw(4, 2, 5, 1, 0), 1);
      send(mkw(4, 2, 5, 1, 1), 1);
      chk(rec_valid == 1'b1, "R1", "launch after resume", AW'(rec_valid), 1);
      for (int s = 0; s < 4; s++)
         chk(rec_attrs[s*AW +: AW] == mkw(4, 2, 5, s / 2, s % 2), "R1",
             $sformatf("slot %0d untouched by bypass", s),
             rec_attrs[s*AW +: AW], mkw(4, 2, 5, s / 2, s % 2));
      consume("R5");

      // R7 batch start mid-record
      set_cfg(3, 2);
      pulse_batch();
      send(mkw(3, 2, 1, 0, 0), 0);
      send(mkw(3, 2, 1, 0, 1), 0);
      send(mkw(3, 2, 1, 1, 0), 1);
      send(mkw(3, 2, 1, 1, 1), 1);
      chk(err_drop == 1'b1 && rec_cont == 1'b1, "R7", "flags before clear",
          AW'({err_drop, rec_cont}), AW'(3));
      consume("R5");
      send(mkw(3, 2, 2, 0, 0), 2);
      send(mkw(3, 2, 2, 0, 1), 2);
      set_cfg(2, 2);
      batch_start = 1'b1; #1;
      chk(in_ready == 1'b0, "R7", "ready low in batch start", AW'(in_ready), '0);
      @(negedge clk);
      batch_start = 1'b0; #1;
      chk(err_drop == 1'b0, "R7", "err_drop cleared", AW'(err_drop), '0);
      @(negedge clk);
      send(mkw(2, 2, 3, 0, 0), 0);
      send(mkw(2, 2, 3, 0, 1), 0);
      chk(rec_valid == 1'b1, "R7", "fresh record launch", AW'(rec_valid), 1);
      chk(rec_attrs[AW-1:0] == mkw(2, 2, 3, 0, 0), "R7", "fill restarted",
          rec_attrs[AW-1:0], mkw(2, 2, 3, 0, 0));
      chk(rec_cont == 1'b0, "R7", "cont cleared", AW'(rec_cont), '0);
      consume("R5");

      // exhaustive sweep of record size and vertex size
      for (int g = 1; g <= 16; g++)
         for (int v = 1; v <= 16; v++)
            run_combo(g, v);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule